// File: doc/BRIEF.md
# Status Register Transfer Unit

This unit keeps a processor's current status word together with five saved-status words, one for each privileged exception mode. It carries out the three instructions that move data between those words and the general registers. Two of them write a status word: one takes a rotated 8-bit immediate and the other takes a general-register operand. The third copies a status word into a general register. Writes to a status word are partial. Four instruction bits enable its bytes one at a time. A user-mode program cannot touch the control byte, and bit 5 of that byte can never be written.

Instructions enter on a valid/ready stream. `inst_ready` stays low while reset is applied and is high at all times after it. The unit never applies back-pressure, because every accepted instruction finishes in the same clock. A beat is accepted on any rising edge where `inst_valid` and `inst_ready` are both high. The producer must hold `inst_word` and `src_value` stable while `inst_valid` is high. The index of the source general register appears on `src_idx` with no delay, and the surrounding register file returns that register's value on `src_value` within the same cycle. The write-back port (`wb_en`, `wb_idx`, `wb_data`) and the error flag are plain combinational pins that belong to the accepted beat. A separate load port writes the current status word directly, for test.

Top module: `status_xfer_unit`

## Requirements
- R1: Decoding uses bits 27:20 and 7:4. The immediate write form has 27:23=00110, 21=1 and 20=0. The register write form has 27:23=00010, 21=1, 20=0 and 7:4=0000. The read form has 27:23=00010, 21:20=00 and 7:4=0000. Every other word is ignored: state stays unchanged, no write-back occurs and no error is raised.
- R2: Bit 22 selects the target word. A value of 0 selects the current status word. A value of 1 selects the saved word that belongs to the current mode.
- R3: The current mode is current-status bits 4:0. The five saved words are selected by mode 0x11, 0x12, 0x13, 0x17 and 0x1B, and each of these modes has its own independent word.
- R4: A saved-word access (bit 22 = 1) made in any other mode raises `bank_err` for that beat. It leaves all state unchanged and produces no write-back.
- R5: Bits 16 to 19 enable status bytes 0 to 3. The mask for byte 0 is 0xDF, so bit 5 is never written by an instruction.
- R6: In user mode (0x10), byte 0 is removed from the mask and only bits 31:8 can change.
- R7: The immediate form's source is bits 7:0 rotated right by twice the value of bits 11:8.
- R8: The register form's source is `src_value`, and `src_idx` equals instruction bits 3:0.
- R9: The new word equals the old word with the masked bits cleared, ORed with (source AND mask). Bits outside the mask keep their old value.
- R10: An accepted read asserts `wb_en` for that cycle only. It sets `wb_idx` to bits 15:12 and `wb_data` to the selected status word.
- R11: A mode change written by an instruction takes effect from the next instruction. Bank selection for the writing instruction uses the old mode.
- R12: `load_en` writes `load_value` into the current status word at the next edge, and it overrides an instruction write to that word in the same cycle.
- R13: `inst_ready` is low during reset and high after it. A beat with `inst_valid` low has no effect. Reset sets the current word to 0x000000D3 and all saved words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | Instruction beat valid |
| inst_ready | output | 1 | Unit accepts beats |
| inst_word | input | 32 | Instruction word |
| src_idx | output | 4 | Index of the operand register (bits 3:0) |
| src_value | input | 32 | Operand value read from `src_idx` |
| load_en | input | 1 | Test load of the current status word |
| load_value | input | 32 | Value for the test load |
| cur_status | output | 32 | Current status word |
| wb_en | output | 1 | General-register write enable |
| wb_idx | output | 4 | General-register write index |
| wb_data | output | 32 | General-register write data |
| bank_err | output | 1 | Saved-word access made in a mode without a bank |

## Verification
The assertions run on every cycle and check the following. An error beat never writes a bank or the current word, and it never produces a write-back. Bits outside the write mask keep their values. Bit 5 and, in user mode, the whole low byte survive instruction writes. A load always lands. At most one bank is written at a time. The bench's scenarios are needed to show the rest. These are the decode of each class, the immediate rotation values, the isolation between the five banks, and the one-instruction delay before a mode change selects a new bank.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_SET_IMM = 2'd1,
    OP_SET_REG = 2'd2,
    OP_GET     = 2'd3
  } srx_op_e;

  localparam logic [4:0] MODE_USER  = 5'h10;
  localparam logic [4:0] MODE_FAST  = 5'h11;
  localparam logic [4:0] MODE_INTR  = 5'h12;
  localparam logic [4:0] MODE_SUPV  = 5'h13;
  localparam logic [4:0] MODE_ABRT  = 5'h17;
  localparam logic [4:0] MODE_UNDF  = 5'h1B;

  localparam int          SAVED_BANKS = 5;
  localparam logic [7:0]  CTRL_BYTE_MASK = 8'hDF;
  localparam logic [31:0] STATUS_RESET   = 32'h0000_00D3;

  // Maps a mode code to a bank slot; bit 3 flags a valid slot.
  function automatic logic [3:0] bank_lookup(input logic [4:0] mode);
    case (mode)
      MODE_FAST: bank_lookup = 4'b1_000;
      MODE_INTR: bank_lookup = 4'b1_001;
      MODE_SUPV: bank_lookup = 4'b1_010;
      MODE_ABRT: bank_lookup = 4'b1_011;
      MODE_UNDF: bank_lookup = 4'b1_100;
      default:   bank_lookup = 4'b0_000;
    endcase
  endfunction

endpackage

// File: rtl/srx_decode.sv
module srx_decode
  import srx_pkg::*;
#(
  parameter int INST_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic [INST_W-1:0] inst_word,
  input  logic              accept,
  output srx_op_e           op,
  output logic              use_saved,
  output logic [3:0]        field_en,
  output logic [3:0]        rot_sel,
  output logic [7:0]        imm8,
  output logic [IDX_W-1:0]  dst_idx,
  output logic [IDX_W-1:0]  opnd_idx
);

  logic [4:0] grp;
  logic       low_nib_zero;

  assign grp          = inst_word[27:23];
  assign low_nib_zero = (inst_word[7:4] == 4'b0000);

  always_comb begin
    op = OP_NONE;
    if (accept) begin
      if (grp == 5'b00110 && inst_word[21:20] == 2'b10)
        op = OP_SET_IMM;
      else if (grp == 5'b00010 && inst_word[21:20] == 2'b10 && low_nib_zero)
        op = OP_SET_REG;
      else if (grp == 5'b00010 && inst_word[21:20] == 2'b00 && low_nib_zero)
        op = OP_GET;
    end
  end

  assign use_saved = inst_word[22];
  assign field_en  = inst_word[19:16];
  assign rot_sel   = inst_word[11:8];
  assign imm8      = inst_word[7:0];
  assign dst_idx   = inst_word[12 +: IDX_W];
  assign opnd_idx  = inst_word[0 +: IDX_W];

endmodule

// File: rtl/srx_operand.sv
module srx_operand
  import srx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  srx_op_e           op,
  input  logic [3:0]        field_en,
  input  logic [3:0]        rot_sel,
  input  logic [7:0]        imm8,
  input  logic [DATA_W-1:0] src_value,
  input  logic              user_mode,
  output logic [DATA_W-1:0] wr_mask,
  output logic [DATA_W-1:0] wr_data
);

  localparam int NUM_BYTES = DATA_W / 8;
  localparam int SH_W      = $clog2(DATA_W) + 1;

  logic [SH_W-1:0]   rot_amt;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] imm_rot;

  assign rot_amt = SH_W'({rot_sel, 1'b0});
  assign imm_ext = DATA_W'(imm8);
  assign imm_rot = (imm_ext >> rot_amt) | (imm_ext << (SH_W'(DATA_W) - rot_amt));

  assign wr_data = (op == OP_SET_IMM) ? imm_rot : src_value;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    if (b == 0) begin : g_ctrl
      assign wr_mask[7:0] = (field_en[0] && !user_mode) ? CTRL_BYTE_MASK : 8'h00;
    end else begin : g_field
      assign wr_mask[8*b +: 8] = field_en[b] ? 8'hFF : 8'h00;
    end
  end

endmodule

// File: rtl/srx_saved_bank.sv
module srx_saved_bank
  import srx_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = SAVED_BANKS,
  parameter int SEL_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel_idx,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_mask,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0]    bank_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_we;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign bank_we[i] = wr_en && (sel_idx == SEL_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)
        bank_q[i] <= '0;
      else if (bank_we[i])
        bank_q[i] <= (bank_q[i] & ~wr_mask) | (wr_data & wr_mask);
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (sel_idx == SEL_W'(i)) rd_data = bank_q[i];
  end

  // R3: one instruction never updates two banks
  a_r3_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

endmodule

// File: rtl/status_xfer_unit.sv
module status_xfer_unit
  import srx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inst_valid,
  output logic              inst_ready,
  input  logic [31:0]       inst_word,
  output logic [IDX_W-1:0]  src_idx,
  input  logic [DATA_W-1:0] src_value,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_value,
  output logic [DATA_W-1:0] cur_status,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              bank_err
);

  localparam int SEL_W = $clog2(SAVED_BANKS);

  logic              rdy_q;
  logic [DATA_W-1:0] cur_q;
  srx_op_e           op;
  logic              use_saved;
  logic [3:0]        field_en;
  logic [3:0]        rot_sel;
  logic [7:0]        imm8;
  logic [IDX_W-1:0]  dst_idx;
  logic [DATA_W-1:0] wr_mask;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] saved_rd;
  logic [3:0]        bank_info;
  logic              bank_ok;
  logic              is_set;
  logic              cur_wr;
  logic              bank_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign inst_ready = rdy_q;

  srx_decode #(.INST_W(32), .IDX_W(IDX_W)) u_decode (
    .inst_word (inst_word),
    .accept    (inst_valid && rdy_q),
    .op        (op),
    .use_saved (use_saved),
    .field_en  (field_en),
    .rot_sel   (rot_sel),
    .imm8      (imm8),
    .dst_idx   (dst_idx),
    .opnd_idx  (src_idx)
  );

  srx_operand #(.DATA_W(DATA_W)) u_operand (
    .op        (op),
    .field_en  (field_en),
    .rot_sel   (rot_sel),
    .imm8      (imm8),
    .src_value (src_value),
    .user_mode (cur_q[4:0] == MODE_USER),
    .wr_mask   (wr_mask),
    .wr_data   (wr_data)
  );

  assign bank_info = bank_lookup(cur_q[4:0]);
  assign bank_ok   = bank_info[3];
  assign is_set    = (op == OP_SET_IMM) || (op == OP_SET_REG);
  assign bank_err  = (op != OP_NONE) && use_saved && !bank_ok;
  assign cur_wr    = is_set && !use_saved;
  assign bank_wr   = is_set && use_saved && bank_ok;

  srx_saved_bank #(.DATA_W(DATA_W), .NUM_BANKS(SAVED_BANKS), .SEL_W(SEL_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_idx (bank_info[SEL_W-1:0]),
    .wr_en   (bank_wr),
    .wr_mask (wr_mask),
    .wr_data (wr_data),
    .rd_data (saved_rd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      cur_q <= DATA_W'(STATUS_RESET);
    else if (load_en)
      cur_q <= load_value;
    else if (cur_wr)
      cur_q <= (cur_q & ~wr_mask) | (wr_data & wr_mask);
  end

  assign cur_status = cur_q;
  assign wb_en      = (op == OP_GET) && !bank_err;
  assign wb_idx     = dst_idx;
  assign wb_data    = use_saved ? saved_rd : cur_q;

  // R4: an illegal saved access touches nothing
  a_r4_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    bank_err |-> (!bank_wr && !wb_en));
  a_r4_err_cur_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_err && !load_en) |=> $stable(cur_status));
  // R9: bits outside the mask are preserved
  a_r9_outside_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_wr && !load_en) |=>
      (((cur_status ^ $past(cur_status)) & ~$past(wr_mask)) == '0));
  // R5: bit 5 never written by an instruction
  a_r5_bit5_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_wr && !load_en) |=> (cur_status[5] == $past(cur_status[5])));
  // R6: user mode cannot alter the control byte
  a_r6_user_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_wr && !load_en && cur_status[4:0] == MODE_USER) |=>
      (cur_status[7:0] == $past(cur_status[7:0])));
  // R12: a load always lands
  a_r12_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cur_status == $past(load_value)));
  // R10: write-back only for an accepted beat
  a_r10_wb_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (inst_valid && inst_ready));

endmodule

// File: tb/status_xfer_unit_tb.sv
module status_xfer_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [31:0] pre;
    logic [31:0] inst;
    logic [31:0] src;
    logic [31:0] exp_status;
    logic        exp_wb;
    logic [31:0] exp_wb_data;
    logic        exp_err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    // R7: imm 0x0F ror 4 into flag byte
    '{32'h0000_00D3, 32'hE328_F20F, 32'h0, 32'hF000_00D3, 1'b0, 32'h0, 1'b0, 8'd7},
    // R9: register form, all fields, bit 5 kept
    '{32'h0000_00D3, 32'hE12F_F003, 32'hAAAA_AAFF, 32'hAAAA_AADF, 1'b0, 32'h0, 1'b0, 8'd9},
    // R6: user mode drops control byte
    '{32'h0000_0010, 32'hE12F_F003, 32'h1234_5678, 32'h1234_5610, 1'b0, 32'h0, 1'b0, 8'd6},
    // R5: control byte only
    '{32'h0000_00D3, 32'hE321_F01F, 32'h0, 32'h0000_001F, 1'b0, 32'h0, 1'b0, 8'd5},
    // R7: ror 8
    '{32'h0000_0013, 32'hE328_F4FF, 32'h0, 32'hFF00_0013, 1'b0, 32'h0, 1'b0, 8'd7},
    // R7: ror 24 into byte 1
    '{32'h0000_0013, 32'hE322_FCAB, 32'h0, 32'h0000_AB13, 1'b0, 32'h0, 1'b0, 8'd7},
    // R8: byte 2 from register
    '{32'h0000_0013, 32'hE124_F001, 32'h1122_3344, 32'h0022_0013, 1'b0, 32'h0, 1'b0, 8'd8},
    // R10: read current word
    '{32'h8000_00D2, 32'hE10F_5000, 32'h0, 32'h8000_00D2, 1'b1, 32'h8000_00D2, 1'b0, 8'd10},
    // R4: saved read in user mode
    '{32'h0000_0010, 32'hE14F_5000, 32'h0, 32'h0000_0010, 1'b0, 32'h0, 1'b1, 8'd4},
    // R4: saved write in system mode
    '{32'h0000_001F, 32'hE368_F20F, 32'h0, 32'h0000_001F, 1'b0, 32'h0, 1'b1, 8'd4},
    // R1: unrelated word ignored
    '{32'h0000_0013, 32'hE081_0002, 32'hFFFF_FFFF, 32'h0000_0013, 1'b0, 32'h0, 1'b0, 8'd1},
    // R5: bit 5 survives a zero write
    '{32'h0000_00F3, 32'hE121_F000, 32'h0, 32'h0000_0020, 1'b0, 32'h0, 1'b0, 8'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inst_valid = 1'b0;
  logic        inst_ready;
  logic [31:0] inst_word = '0;
  logic [3:0]  src_idx;
  logic [31:0] src_value = '0;
  logic        load_en = 1'b0;
  logic [31:0] load_value = '0;
  logic [31:0] cur_status;
  logic        wb_en;
  logic [3:0]  wb_idx;
  logic [31:0] wb_data;
  logic        bank_err;

  int n_checks = 0;
  int n_fail   = 0;
  logic        s_wb, s_err;
  logic [3:0]  s_idx, s_src;
  logic [31:0] s_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_xfer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_ready(inst_ready),
    .inst_word(inst_word), .src_idx(src_idx), .src_value(src_value),
    .load_en(load_en), .load_value(load_value), .cur_status(cur_status),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data), .bank_err(bank_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic load_status(input logic [31:0] v);
    @(negedge clk);
    load_en = 1'b1; load_value = v;
    @(posedge clk); #1;
    load_en = 1'b0;
  endtask

  // Drive one beat, capture combinational outputs before the edge, status after.
  task automatic issue(input logic v, input logic [31:0] w, input logic [31:0] s);
    @(negedge clk);
    inst_valid = v; inst_word = w; src_value = s;
    #1;
    s_wb = wb_en; s_err = bank_err; s_idx = wb_idx; s_data = wb_data; s_src = src_idx;
    @(posedge clk); #1;
    inst_valid = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] bank_val [5];
    logic [4:0]  modes [5];
    modes = '{5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};

    // R13: reset behaviour
    repeat (3) @(posedge clk);
    #1;
    check("R13 ready low in reset", {31'b0, inst_ready}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R13 ready after reset", {31'b0, inst_ready}, 32'h1);
    check("R13 reset status", cur_status, 32'h0000_00D3);
    check("R13 no wb at rest", {31'b0, wb_en}, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec %0d", VEC[i].req, i);
      load_status(VEC[i].pre);
      issue(1'b1, VEC[i].inst, VEC[i].src);
      check({tg, " wb_en"}, {31'b0, s_wb}, {31'b0, VEC[i].exp_wb});
      check({tg, " err"}, {31'b0, s_err}, {31'b0, VEC[i].exp_err});
      if (VEC[i].exp_wb) begin
        check({tg, " wb_data"}, s_data, VEC[i].exp_wb_data);
        check({tg, " wb_idx"}, {28'b0, s_idx}, 32'h5);
      end
      check({tg, " status"}, cur_status, VEC[i].exp_status);
    end

    // R8: operand index follows bits 3:0
    issue(1'b1, 32'hE12F_F00B, 32'h0);
    check("R8 src_idx", {28'b0, s_src}, 32'hB);

    // R3 / R2: each bank holds its own value
    for (int k = 0; k < 5; k++) begin
      bank_val[k] = 32'h5A00_000C | (32'(k + 1) << 16);
      load_status({27'b0, modes[k]});
      issue(1'b1, 32'hE16F_F000, bank_val[k]);
      check("R2 saved write leaves current", cur_status, {27'b0, modes[k]});
    end
    for (int k = 0; k < 5; k++) begin
      load_status({27'b0, modes[k]});
      issue(1'b1, 32'hE14F_7000, 32'h0);
      check("R3 bank readback", s_data, bank_val[k]);
      check("R10 bank read idx", {28'b0, s_idx}, 32'h7);
      check("R10 bank read wb", {31'b0, s_wb}, 32'h1);
    end

    // R10: wb_en lasts one cycle only
    @(negedge clk); #1;
    check("R10 wb drops after beat", {31'b0, wb_en}, 32'h0);

    // R11: mode change applies from the next instruction
    load_status(32'h0000_0013);
    issue(1'b1, 32'hE321_F012, 32'h0);
    check("R11 mode written", cur_status, 32'h0000_0012);
    issue(1'b1, 32'hE14F_7000, 32'h0);
    check("R11 next selects new bank", s_data, bank_val[1]);
    // writing saved word while also changing mode is not possible in one beat;
    // saved write in supervisor must land in the supervisor bank
    load_status(32'h0000_0013);
    issue(1'b1, 32'hE161_F000, 32'h0000_0000);
    issue(1'b1, 32'hE14F_7000, 32'h0);
    check("R11 old-mode bank used", s_data, 32'h5A03_0000);

    // R12: load overrides an instruction write
    @(negedge clk);
    load_en = 1'b1; load_value = 32'h0000_001B;
    inst_valid = 1'b1; inst_word = 32'hE12F_F000; src_value = 32'hFFFF_FFFF;
    @(posedge clk); #1;
    load_en = 1'b0; inst_valid = 1'b0;
    check("R12 load wins", cur_status, 32'h0000_001B);

    // R13: beat without valid has no effect
    issue(1'b0, 32'hE12F_F000, 32'hFFFF_FFFF);
    check("R13 invalid write ignored", cur_status, 32'h0000_001B);
    issue(1'b0, 32'hE10F_3000, 32'h0);
    check("R13 invalid read no wb", {31'b0, s_wb}, 32'h0);

    // R1: near-miss encoding (bits 7:4 nonzero) ignored
    issue(1'b1, 32'hE12F_F093, 32'hFFFF_FFFF);
    check("R1 near-miss ignored", cur_status, 32'h0000_001B);
    check("R1 near-miss no err", {31'b0, s_err}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule